// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator Bank

This block generates one or two independent pulse-width modulated outputs from a single input clock. Each channel has a small set of word-addressed registers. One holds a clock divider value and a stop-mode bit. One holds the high-time count and a force-high flag. One holds the period limit. The divider slows the count rate. A period counter steps once per divided tick and wraps at the programmed limit. The output is high while the count is below the high-time count, and low for the rest of the period.

Software writes new settings at any time. The running channel picks them up only when the current period ends, so a half-applied setting never shapes a period. Each channel has its own enable pin. Dropping enable either lets the current period finish or stops the output at once, depending on the stop-mode bit.

Top module: `pwm_bank`

## Requirements
- R1: Each channel's registers are selected by address bits [3:2]. Code 0 is the control word: divider in bits [5:0], stop-mode bit in bit 6. Code 1 is the duty word: high count in bits [9:0], force-high flag in bit 10. Code 2 is the period word: limit in bits [9:0]. Code 3 reads zero and ignores writes. Every field reads back the last value written, other bits read zero, and address bits [1:0] are ignored.
- R2: Address bit 4 selects the channel, so the second channel's bank sits 0x10 above the first. The two channels' registers and outputs do not affect each other.
- R3: Once enable is sampled high on a clock edge, the period starts on the next cycle. The period lasts (divider+1)×(limit+1) clock cycles and then repeats.
- R4: With the force-high flag clear, the output is high for the first (divider+1)×count cycles of each period and low for the rest.
- R5: With the force-high flag set, the output is high for the whole period whatever the count.
- R6: A count of 0 with the flag clear gives a constantly low output. A count above limit+1 gives a constantly high output.
- R7: Register writes made while a channel runs do not alter the current period. They take effect from the next period boundary.
- R8: With stop-mode 0, a channel whose enable is sampled low finishes its current period unchanged and then drives low.
- R9: With stop-mode 1 (read live from the register), the output is low from the cycle after enable is sampled low.
- R10: A disabled channel drives its output low. A re-enabled channel always begins a fresh period from count zero.
- R11: During and after reset, outputs are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counting and register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Selects the block for a register access |
| bus_we | input | 1 | 1 = write on this clock edge, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| ch_en | input | NUM_CH | Per-channel enable |
| pwm_out | output | NUM_CH | Per-channel modulated output |

## Verification
The bench builds the block with both channels present and the default 6-bit divider and 10-bit limit. This puts the second bank's address decode and concurrent operation of the two channels within reach. It also makes the extreme settings reachable: a divider of 63 and a limit of 1023 both fit in short runs. Stop-mode behaviour, mid-period duty rewrites and the count-above-limit case are each aimed at a single channel and checked cycle by cycle against an expected waveform.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DUTY = 2'd1,
    REG_PER  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2
  } ch_state_e;

  localparam int unsigned BANK_SEL_BIT = 4;
  localparam int unsigned REG_LSB      = 2;

endpackage

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned PRE_W  = 6,
  parameter int unsigned PER_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [PRE_W-1:0]  prog_pre,
  output logic              prog_stop,
  output logic [PER_W-1:0]  prog_dc,
  output logic              prog_full,
  output logic [PER_W-1:0]  prog_pv,
  output logic [DATA_W-1:0] rdata
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             stop_q, stop_d;
  logic [PER_W-1:0] dc_q, dc_d;
  logic             full_q, full_d;
  logic [PER_W-1:0] pv_q, pv_d;
  logic             wdata_unused;

  assign wdata_unused = ^wdata;

  always_comb begin
    pre_d  = pre_q;
    stop_d = stop_q;
    dc_d   = dc_q;
    full_d = full_q;
    pv_d   = pv_q;
    if (wr_en) begin
      case (reg_sel)
        REG_CTRL: begin
          pre_d  = wdata[PRE_W-1:0];
          stop_d = wdata[PRE_W];
        end
        REG_DUTY: begin
          dc_d   = wdata[PER_W-1:0];
          full_d = wdata[PER_W];
        end
        REG_PER:  pv_d = wdata[PER_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      stop_q <= 1'b0;
      dc_q   <= '0;
      full_q <= 1'b0;
      pv_q   <= '0;
    end else if (wr_en) begin
      pre_q  <= pre_d;
      stop_q <= stop_d;
      dc_q   <= dc_d;
      full_q <= full_d;
      pv_q   <= pv_d;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_CTRL: rdata = DATA_W'({stop_q, pre_q});
      REG_DUTY: rdata = DATA_W'({full_q, dc_q});
      REG_PER:  rdata = DATA_W'(pv_q);
      default:  rdata = '0;
    endcase
  end

  assign prog_pre  = pre_q;
  assign prog_stop = stop_q;
  assign prog_dc   = dc_q;
  assign prog_full = full_q;
  assign prog_pv   = pv_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:PER_W+1] == '0); // R1

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned PRE_W = 6,
  parameter int unsigned PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic [PER_W-1:0] per_lim,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [PER_W-1:0] per_cnt,
  output logic             wrap
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             tick;

  assign tick = run && (pre_q == pre_lim);
  assign wrap = tick && (per_q == per_lim);

  always_comb begin
    pre_d = pre_q;
    per_d = per_q;
    if (!run) begin
      pre_d = '0;
      per_d = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        per_d = (per_q == per_lim) ? '0 : per_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else begin
      pre_q <= pre_d;
      per_q <= per_d;
    end
  end

  assign pre_cnt = pre_q;
  assign per_cnt = per_q;

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= pre_lim); // R3
  AST_PER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= per_lim); // R3

endmodule

// File: rtl/pwm_ch_ctrl.sv
module pwm_ch_ctrl
  import pwm_bank_pkg::*;
#(
  parameter int unsigned PRE_W = 6,
  parameter int unsigned PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] prog_pre,
  input  logic             prog_stop,
  input  logic [PER_W-1:0] prog_dc,
  input  logic             prog_full,
  input  logic [PER_W-1:0] prog_pv,
  output logic             pwm_o
);

  ch_state_e        state_q, state_d;
  logic             load;
  logic [PRE_W-1:0] act_pre_q;
  logic [PER_W-1:0] act_pv_q;
  logic [PER_W-1:0] act_dc_q;
  logic             act_full_q;
  logic             run;
  logic             wrap;
  logic [PRE_W-1:0] pre_cnt;
  logic [PER_W-1:0] per_cnt;
  logic             level_hi;

  assign run = (state_q != CH_IDLE);

  pwm_timebase #(
    .PRE_W (PRE_W),
    .PER_W (PER_W)
  ) tb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pre_lim (act_pre_q),
    .per_lim (act_pv_q),
    .pre_cnt (pre_cnt),
    .per_cnt (per_cnt),
    .wrap    (wrap)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    case (state_q)
      CH_IDLE: begin
        if (en) begin
          state_d = CH_RUN;
          load    = 1'b1;
        end
      end
      CH_RUN: begin
        if (!en) begin
          state_d = (prog_stop || wrap) ? CH_IDLE : CH_DRAIN;
        end else if (wrap) begin
          load = 1'b1;
        end
      end
      CH_DRAIN: begin
        if (!en && prog_stop) begin
          state_d = CH_IDLE;
        end else if (wrap) begin
          if (en) begin
            state_d = CH_RUN;
            load    = 1'b1;
          end else begin
            state_d = CH_IDLE;
          end
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pre_q  <= '0;
      act_pv_q   <= '0;
      act_dc_q   <= '0;
      act_full_q <= 1'b0;
    end else if (load) begin
      act_pre_q  <= prog_pre;
      act_pv_q   <= prog_pv;
      act_dc_q   <= prog_dc;
      act_full_q <= prog_full;
    end
  end

  assign level_hi = act_full_q || (per_cnt < act_dc_q);
  assign pwm_o    = run && level_hi;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(act_dc_q) && $stable(act_pv_q) && $stable(act_pre_q))); // R7
  AST_HARD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !en && prog_stop) |=> !pwm_o); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_IDLE && $past(state_q == CH_IDLE)) |-> (per_cnt == '0 && pre_cnt == '0)); // R10
  AST_DRAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_RUN && !en && !prog_stop && !wrap) |=> (state_q == CH_DRAIN)); // R8

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned PRE_W  = 6,
  parameter int unsigned PER_W  = 10,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int unsigned REG_MSB = REG_LSB + 1;

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic              addr_ch;
  reg_sel_e          reg_sel;
  logic              addr_unused;
  logic [NUM_CH-1:0] ch_wr;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign addr_ch     = bus_addr[BANK_SEL_BIT];
  assign addr_unused = ^bus_addr;

  always_comb begin
    case (bus_addr[REG_MSB:REG_LSB])
      2'd0:    reg_sel = REG_CTRL;
      2'd1:    reg_sel = REG_DUTY;
      2'd2:    reg_sel = REG_PER;
      default: reg_sel = REG_NONE;
    endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [PRE_W-1:0] prog_pre;
    logic             prog_stop;
    logic [PER_W-1:0] prog_dc;
    logic             prog_full;
    logic [PER_W-1:0] prog_pv;

    assign ch_wr[g] = bus_sel && bus_we && (addr_ch == 1'(g));

    pwm_ch_regs #(
      .PRE_W  (PRE_W),
      .PER_W  (PER_W),
      .DATA_W (DATA_W)
    ) regs_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_en     (ch_wr[g]),
      .reg_sel   (reg_sel),
      .wdata     (bus_wdata),
      .prog_pre  (prog_pre),
      .prog_stop (prog_stop),
      .prog_dc   (prog_dc),
      .prog_full (prog_full),
      .prog_pv   (prog_pv),
      .rdata     (ch_rdata[g])
    );

    pwm_ch_ctrl #(
      .PRE_W (PRE_W),
      .PER_W (PER_W)
    ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .en        (ch_en[g]),
      .prog_pre  (prog_pre),
      .prog_stop (prog_stop),
      .prog_dc   (prog_dc),
      .prog_full (prog_full),
      .prog_pv   (prog_pv),
      .pwm_o     (pwm_out[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_sel && (addr_ch == 1'(c))) begin
        bus_rdata = ch_rdata[c];
      end
    end
  end

  AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ch_wr)); // R2
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_sync_n |-> (pwm_out == '0)); // R11

endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;

  localparam int NCH = 2;
  localparam int NV  = 8;
  // columns: divider, limit, count, force-high, period cycles, high cycles
  localparam int VT [0:NV-1][0:5] = '{
    '{ 0,    9,    3, 0,   10,    3},
    '{ 2,    4,    2, 0,   15,    6},
    '{ 1,    7,    0, 0,   16,    0},
    '{ 0,    5,    2, 1,    6,    6},
    '{ 3,    3,    9, 0,   16,   16},
    '{ 0,    0,    1, 0,    1,    1},
    '{63,    1,    1, 0,  128,   64},
    '{ 0, 1023, 1023, 0, 1024, 1023}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel;
  logic            bus_we;
  logic [4:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  ch_en;
  logic [NCH-1:0]  pwm_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_en     (ch_en),
    .pwm_out   (pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic program_ch(input logic [4:0] base, input int ctrl, input int duty, input int per);
    bus_write(base + 5'h00, 32'(ctrl));
    bus_write(base + 5'h04, 32'(duty));
    bus_write(base + 5'h08, 32'(per));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int bad;
    int highs;
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; ch_en = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 outputs in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(5'h04, rd); chk("R11 duty after reset", int'(rd), 0);
    bus_read(5'h18, rd); chk("R11 ch1 period after reset", int'(rd), 0);
    chk("R11 outputs after reset", int'(pwm_out), 0);

    // R1 field masks and reserved address
    bus_write(5'h00, 32'hFFFF_FFFF); bus_read(5'h00, rd); chk("R1 control mask", int'(rd), 'h7F);
    bus_write(5'h04, 32'hFFFF_FFFF); bus_read(5'h04, rd); chk("R1 duty mask", int'(rd), 'h7FF);
    bus_write(5'h0A, 32'hFFFF_FFFF); bus_read(5'h08, rd); chk("R1 period mask, low addr bits ignored", int'(rd), 'h3FF);
    bus_write(5'h0C, 32'hFFFF_FFFF); bus_read(5'h0C, rd); chk("R1 code 3 reads zero", int'(rd), 0);
    // R2 second bank independence
    bus_write(5'h10, 32'h25); bus_read(5'h10, rd); chk("R2 ch1 control", int'(rd), 'h25);
    bus_read(5'h00, rd); chk("R2 ch0 untouched by ch1 write", int'(rd), 'h7F);
    chk("R10 disabled outputs low", int'(pwm_out), 0);

    // vector table: R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      program_ch(5'h00, 64 + VT[v][0], VT[v][3] * 1024 + VT[v][2], VT[v][1]);
      @(negedge clk); ch_en[0] = 1'b1;
      bad = 0; highs = 0;
      for (int i = 0; i < 2 * VT[v][4]; i++) begin
        @(negedge clk);
        if (pwm_out[0] != ((i % VT[v][4]) < VT[v][5])) bad++;
        if (i < VT[v][4] && pwm_out[0]) highs++;
      end
      chk($sformatf("R3 R4 R5 R6 R10 vec %0d waveform errors", v), bad, 0);
      chk($sformatf("R4 vec %0d high cycles", v), highs, VT[v][5]);
      ch_en[0] = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R7 mid-period duty rewrite
    program_ch(5'h00, 64, 3, 9);
    @(negedge clk); ch_en[0] = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out[0] != ((i < 10) ? (i < 3) : ((i - 10) < 7))) bad++;
      if (i == 1) begin bus_sel = 1; bus_we = 1; bus_addr = 5'h04; bus_wdata = 32'd7; end
      if (i == 2) begin bus_sel = 0; bus_we = 0; end
    end
    chk("R7 new duty only after boundary", bad, 0);
    ch_en[0] = 1'b0;
    repeat (3) @(negedge clk);

    // R8 graceful stop
    program_ch(5'h00, 0, 8, 9);
    @(negedge clk); ch_en[0] = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_out[0] != ((i < 10) ? (i < 8) : 1'b0)) bad++;
      if (i == 1) ch_en[0] = 1'b0;
    end
    chk("R8 period completes then low", bad, 0);

    // R9 immediate stop
    bus_write(5'h00, 32'd64);
    @(negedge clk); ch_en[0] = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out[0] != (i < 2)) bad++;
      if (i == 1) ch_en[0] = 1'b0;
    end
    chk("R9 low right after disable", bad, 0);

    // R2 both channels running together
    program_ch(5'h00, 64, 1, 3);
    program_ch(5'h10, 65, 3, 4);
    @(negedge clk); ch_en = 2'b11;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out[0] != ((i % 4) < 1)) bad++;
      if (pwm_out[1] != ((i % 10) < 6)) bad++;
    end
    chk("R2 concurrent channel waveforms", bad, 0);
    ch_en = 2'b00;
    repeat (3) @(negedge clk);
    chk("R10 both low after disable", int'(pwm_out), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule